// File: doc/BRIEF.md
# Debug Port Authentication Gate

This block stands between a debug/test port and the internal debug registers and decides whether the port may use them. A user submits a 512-bit secret. The gate hands the whole secret to an external keyed-hash engine through a start/done handshake. It then compares the returned 256-bit digest with an expected digest that a fixed input supplies. Only a full match opens the port. While the port is open, debug access requests pass through. Otherwise they are refused.

The comparison runs over a fixed number of lanes, one lane per cycle. A decision therefore takes the same time whether the first bit or the last bit differs. Wrong attempts in a row are counted. When the count reaches a threshold, the gate enters a timed lockout and ignores all submissions. When the lockout expires, the count is left one short of the threshold, so a single further miss locks the gate again. The secret holding register is wiped in the cycle after it is handed to the engine. The digest holding register is wiped as the decision is taken, so nothing sensitive remains when the port opens.

Top module: `dbg_auth_gate`

## Requirements
- R1: After reset, `auth_granted`, `locked`, `busy`, `hash_start` and `acc_ok` are all 0.
- R2: `acc_ok` is 1 only while the gate is open and `acc_req` is 1. Requests made while idle or locked get `acc_ok` = 0.
- R3: A `pw_valid` pulse sampled while idle produces, in the next cycle, a single-cycle `hash_start` with `hash_msg` equal to all 512 bits of `pw_data`. `busy` stays 1 from that cycle until the decision.
- R4: In the cycle after `hash_start`, `hash_msg` reads all zeros.
- R5: The decision (`busy` falling, `auth_granted` or `locked` rising) comes exactly DIGEST_W/LANE_W cycles after the clock edge that samples `hash_done`, for matching and mismatching digests alike.
- R6: `auth_granted` rises only when the returned digest equals `expected_digest` in every bit. A change to any single bit of the secret, including bit 511 or bit 0, is refused.
- R7: FAIL_LIMIT (default 3) consecutive failures raise `locked`. A successful authentication resets the failure count to zero.
- R8: `locked` stays high for exactly LOCK_CYCLES (default 1024) cycles. Throughout the lockout, `pw_valid` produces no `hash_start` and `acc_req` produces no `acc_ok`.
- R9: After a lockout expires, one wrong attempt raises `locked` again.
- R10: While the gate is open, `pw_valid` is ignored. `deauth` returns the gate to idle, with `auth_granted` = 0, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pw_valid | input | 1 | Submit the secret on `pw_data` |
| pw_data | input | 512 | Secret supplied by the user |
| deauth | input | 1 | End the open session |
| acc_req | input | 1 | Debug register access request |
| acc_ok | output | 1 | Access request permitted |
| expected_digest | input | 256 | Digest that a valid secret must produce |
| hash_start | output | 1 | Start pulse to the hash engine |
| hash_msg | output | 512 | Message to the hash engine, valid with `hash_start` |
| hash_done | input | 1 | Hash engine result valid |
| hash_digest | input | 256 | Digest from the hash engine |
| auth_granted | output | 1 | Gate open |
| locked | output | 1 | Lockout in progress |
| busy | output | 1 | Authentication in progress |

## Verification
The bench sends secrets that differ from the valid one only in the top bit or only in the bottom bit. A design that zero-pads or truncates the secret would grant one of them. A comparator that exits early would decide the bottom-bit case sooner than the others, and the latency check catches that. The failure counter is exercised twice: two misses following a success must not lock, which catches a counter that is not cleared on success. A single miss after an expired lockout must lock again, which catches a count that is not kept. During the lockout the bench holds `pw_valid` and `acc_req` high throughout and measures the lockout length. A gate that starts a hash, grants access or releases one cycle early or late is reported.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;
  typedef enum logic [2:0] {
    GS_IDLE   = 3'd0,
    GS_LAUNCH = 3'd1,
    GS_WAIT   = 3'd2,
    GS_CMP    = 3'd3,
    GS_OPEN   = 3'd4,
    GS_LOCK   = 3'd5
  } gate_state_e;
endpackage

// File: rtl/dbg_auth_rst_sync.sv
module dbg_auth_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dbg_auth_cmp.sv
// Lane-serial equality check: always walks every lane, no early exit.
module dbg_auth_cmp #(
  parameter int W      = 256,
  parameter int LANE_W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         last,
  output logic         match
);
  localparam int NLANE = W / LANE_W;
  localparam int IW    = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic [NLANE-1:0] lane_ne;
  logic [IW-1:0]    idx_q, idx_d;
  logic             acc_q, acc_d;
  logic             cur_ne;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_ne[g] = |(a[g*LANE_W +: LANE_W] ^ b[g*LANE_W +: LANE_W]);
  end

  assign cur_ne = lane_ne[idx_q];
  assign last   = run && (idx_q == IW'(NLANE-1));
  assign match  = !(acc_q || cur_ne);

  always_comb begin
    idx_d = '0;
    acc_d = 1'b0;
    if (run && !last) begin
      idx_d = idx_q + 1'b1;
      acc_d = acc_q | cur_ne;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/dbg_auth_lock.sv
// Consecutive-failure counter and lockout down-counter.
module dbg_auth_lock #(
  parameter int FAIL_LIMIT  = 3,
  parameter int LOCK_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_evt,
  input  logic pass_evt,
  output logic trip,
  output logic expire
);
  localparam int CW = $clog2(FAIL_LIMIT + 1);
  localparam int TW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          act_q, act_d;

  assign trip   = fail_evt && (cnt_q >= CW'(FAIL_LIMIT-1));
  assign expire = act_q && (tmr_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (pass_evt)      cnt_d = '0;
    else if (trip)     cnt_d = CW'(FAIL_LIMIT);
    else if (fail_evt) cnt_d = cnt_q + 1'b1;
    else if (expire)   cnt_d = CW'(FAIL_LIMIT-1);
  end

  always_comb begin
    tmr_d = tmr_q;
    act_d = act_q;
    if (trip) begin
      tmr_d = TW'(LOCK_CYCLES-1);
      act_d = 1'b1;
    end else if (expire) begin
      act_d = 1'b0;
    end else if (act_q) begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmr_q <= tmr_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate #(
  parameter int SECRET_W    = 512,
  parameter int DIGEST_W    = 256,
  parameter int LANE_W      = 32,
  parameter int FAIL_LIMIT  = 3,
  parameter int LOCK_CYCLES = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pw_valid,
  input  logic [SECRET_W-1:0] pw_data,
  input  logic                deauth,
  input  logic                acc_req,
  output logic                acc_ok,
  input  logic [DIGEST_W-1:0] expected_digest,
  output logic                hash_start,
  output logic [SECRET_W-1:0] hash_msg,
  input  logic                hash_done,
  input  logic [DIGEST_W-1:0] hash_digest,
  output logic                auth_granted,
  output logic                locked,
  output logic                busy
);
  import dbg_auth_pkg::*;

  logic        srst_n;
  gate_state_e st_q, st_d;

  logic [SECRET_W-1:0] secret_q, secret_d;
  logic                secret_en;
  logic [DIGEST_W-1:0] dig_q, dig_d;
  logic                dig_en;

  logic cmp_run, cmp_last, cmp_match;
  logic fail_evt, pass_evt, trip, expire;

  dbg_auth_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign cmp_run = (st_q == GS_CMP);

  dbg_auth_cmp #(.W(DIGEST_W), .LANE_W(LANE_W)) u_cmp (
    .clk(clk), .rst_n(srst_n), .run(cmp_run),
    .a(dig_q), .b(expected_digest),
    .last(cmp_last), .match(cmp_match)
  );

  assign fail_evt = cmp_last && !cmp_match;
  assign pass_evt = cmp_last &&  cmp_match;

  dbg_auth_lock #(.FAIL_LIMIT(FAIL_LIMIT), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(srst_n),
    .fail_evt(fail_evt), .pass_evt(pass_evt),
    .trip(trip), .expire(expire)
  );

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_IDLE:   if (pw_valid) st_d = GS_LAUNCH;
      GS_LAUNCH: st_d = GS_WAIT;
      GS_WAIT:   if (hash_done) st_d = GS_CMP;
      GS_CMP: begin
        if (pass_evt)  st_d = GS_OPEN;
        else if (trip) st_d = GS_LOCK;
        else if (fail_evt) st_d = GS_IDLE;
      end
      GS_OPEN:   if (deauth) st_d = GS_IDLE;
      GS_LOCK:   if (expire) st_d = GS_IDLE;
      default:   st_d = GS_IDLE;
    endcase
  end

  // secret holding register: loaded on submit, wiped right after hand-off
  always_comb begin
    secret_en = 1'b0;
    secret_d  = '0;
    if (st_q == GS_IDLE && pw_valid) begin
      secret_en = 1'b1;
      secret_d  = pw_data;
    end else if (st_q == GS_LAUNCH) begin
      secret_en = 1'b1;
    end
  end

  // digest holding register: loaded on done, wiped as the decision is taken
  always_comb begin
    dig_en = 1'b0;
    dig_d  = '0;
    if (st_q == GS_WAIT && hash_done) begin
      dig_en = 1'b1;
      dig_d  = hash_digest;
    end else if (cmp_last) begin
      dig_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= GS_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        secret_q <= '0;
    else if (secret_en) secret_q <= secret_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     dig_q <= '0;
    else if (dig_en) dig_q <= dig_d;
  end

  assign hash_start   = (st_q == GS_LAUNCH);
  assign hash_msg     = secret_q;
  assign auth_granted = (st_q == GS_OPEN);
  assign locked       = (st_q == GS_LOCK);
  assign busy         = (st_q == GS_LAUNCH) || (st_q == GS_WAIT) || (st_q == GS_CMP);
  assign acc_ok       = acc_req && auth_granted;
endmodule

// File: rtl/dbg_auth_gate_chk.sv
module dbg_auth_gate_chk #(
  parameter int SECRET_W = 512
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_ok,
  input logic                hash_start,
  input logic [SECRET_W-1:0] hash_msg,
  input logic                auth_granted,
  input logic                locked,
  input logic                busy
);
  // R2
  acc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> auth_granted);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> !hash_start);
  // R4
  secret_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> (hash_msg == '0));
  // R8
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!hash_start && !busy && !acc_ok));
  // R7
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(busy));
  // R6
  grant_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auth_granted) |-> $past(busy));
  // R1
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(auth_granted && locked));
endmodule

bind dbg_auth_gate dbg_auth_gate_chk #(.SECRET_W(SECRET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ok(acc_ok), .hash_start(hash_start),
  .hash_msg(hash_msg), .auth_granted(auth_granted), .locked(locked), .busy(busy)
);

// File: tb/dbg_auth_gate_test.sv
module dbg_auth_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 512;
  localparam int DW = 256;
  localparam int LW = 32;
  localparam int NL = DW / LW;
  localparam int LOCKN = 1024;
  localparam int HLAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pw_valid = 1'b0;
  logic [SW-1:0] pw_data = '0;
  logic deauth = 1'b0;
  logic acc_req = 1'b0;
  logic acc_ok;
  logic [DW-1:0] expected_digest;
  logic hash_start;
  logic [SW-1:0] hash_msg;
  logic hash_done = 1'b0;
  logic [DW-1:0] hash_digest = '0;
  logic auth_granted, locked, busy;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int done_cyc = 0;
  int decision_cyc = 0;
  logic [1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_auth_gate uut (
    .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_data(pw_data),
    .deauth(deauth), .acc_req(acc_req), .acc_ok(acc_ok),
    .expected_digest(expected_digest), .hash_start(hash_start),
    .hash_msg(hash_msg), .hash_done(hash_done), .hash_digest(hash_digest),
    .auth_granted(auth_granted), .locked(locked), .busy(busy)
  );

  function automatic logic [DW-1:0] fold(input logic [SW-1:0] m);
    return m[SW-1:DW] ^ m[DW-1:0] ^ {8{32'hA5C3_0F1E}};
  endfunction

  localparam logic [SW-1:0] GOOD = {16{32'h3C96_E10B}};
  assign expected_digest = fold(GOOD);

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // hash engine stand-in
  initial begin
    logic [SW-1:0] m;
    forever begin
      @(negedge clk);
      if (hash_start) begin
        m = hash_msg;
        repeat (HLAT) @(negedge clk);
        hash_digest = fold(m);
        hash_done = 1'b1;
        done_cyc = cyc;
        @(negedge clk);
        hash_done = 1'b0;
      end
    end
  end

  // monitor: pops expected outcome at each decision
  initial begin
    logic bprev = 1'b0;
    logic [1:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && bprev && !busy) begin
        decision_cyc = cyc;
        if (exp_q.size() == 0) begin
          chk("R6 unexpected decision", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk("R6/R7 outcome {granted,locked}", {auth_granted, locked}, e);
          chk("R5 decision latency", cyc - done_cyc, NL + 1);
        end
      end
      bprev = busy;
    end
  end

  task automatic submit(input logic [SW-1:0] pw, input logic g, input logic l);
    exp_q.push_back({g, l});
    @(negedge clk); pw_valid = 1'b1; pw_data = pw;
    @(negedge clk); pw_valid = 1'b0;
    chk("R3 start pulse", hash_start, 1);
    chk("R3 full message", hash_msg, pw);
    chk("R3 busy", busy, 1);
    @(negedge clk);
    chk("R4 secret wiped", hash_msg, 0);
    chk("R3 single pulse", hash_start, 0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic ride_lockout(input string tag);
    logic saw_start = 1'b0;
    logic saw_acc = 1'b0;
    while (locked) begin
      pw_valid = 1'b1; pw_data = GOOD; acc_req = 1'b1;
      saw_start |= hash_start; saw_acc |= acc_ok;
      @(negedge clk);
    end
    pw_valid = 1'b0; acc_req = 1'b0;
    chk({tag, " lockout length"}, cyc - decision_cyc, LOCKN);
    chk("R8 no hash start while locked", saw_start, 0);
    chk("R8 no access while locked", saw_acc, 0);
    @(negedge clk);
    chk("R8 submission during lock not captured", hash_start, 0);
    chk("R8 idle after lockout", {auth_granted, locked, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [SW-1:0] bad_hi, bad_lo;
    bad_hi = GOOD ^ {1'b1, {(SW-1){1'b0}}};
    bad_lo = GOOD ^ {{(SW-1){1'b0}}, 1'b1};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 reset outputs", {auth_granted, locked, busy, hash_start, acc_ok}, 0);
    // R2
    acc_req = 1'b1; @(negedge clk);
    chk("R2 refused while idle", acc_ok, 0);
    acc_req = 1'b0;

    // R6 / R5: late-lane and early-lane mismatches
    submit(bad_hi, 0, 0);
    submit(bad_lo, 0, 0);
    // R6 correct secret; R7 count clears
    submit(GOOD, 1, 0);
    acc_req = 1'b1; @(negedge clk);
    chk("R2 granted access", acc_ok, 1);
    acc_req = 1'b0;
    // R10 submissions ignored while open
    pw_valid = 1'b1; pw_data = bad_hi; @(negedge clk);
    pw_valid = 1'b0;
    chk("R10 no start while open", hash_start, 0);
    @(negedge clk);
    chk("R10 still open", {auth_granted, hash_start}, 2'b10);
    deauth = 1'b1; @(negedge clk);
    deauth = 1'b0;
    chk("R10 deauth closes", {auth_granted, locked}, 0);
    acc_req = 1'b1; @(negedge clk);
    chk("R2 refused after deauth", acc_ok, 0);
    acc_req = 1'b0;

    // R7 counter reset by success: two misses do not lock, third does
    submit(bad_lo, 0, 0);
    submit(bad_hi, 0, 0);
    submit(bad_lo, 0, 1);
    ride_lockout("R8");

    // R9 one miss after expiry re-locks
    submit(bad_hi, 0, 1);
    ride_lockout("R9");
    submit(GOOD, 1, 0);
    chk("R7 granted after lockouts", auth_granted, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule